// File: doc/BRIEF.md
# Acquisition Scan Sequencer and Trigger Control

This block sits between a byte-wide register bus and a 64-input analog acquisition front end. Software programs a channel window, a trigger source and an interrupt condition. Each accepted trigger produces a one-cycle start-of-conversion strobe for the current multiplexer channel. When the converter reports completion, the sample is written left-justified into a sample FIFO, and the channel select advances through the window. After the upper bound it wraps back to the lower bound.

Triggers come from one of four sources: a write to the data location, a falling edge on the external trigger pin, a rising edge on that pin, or a pacer tick supplied from outside. Software reads samples back one byte at a time. It watches FIFO occupancy through a status byte, or it uses an interrupt request whose cause is chosen by a mode field. The input configuration is passed straight through to the front end: single-ended versus differential, and unipolar versus bipolar.

Top module: `acq_scan_ctrl`

## Requirements
- R1: Byte offset 2 holds the low channel bound and offset 3 holds the high channel bound, each in bits 5:0, and both read back. Writing either offset reloads the current channel select with the low bound within two cycles. After reset the channel select is 0.
- R2: Each completed conversion advances the channel select by one. A conversion that ends at or above the effective high bound returns the select to the low bound. With equal bounds the same channel repeats.
- R3: When mode bit 5 is 0 (differential), the effective high bound is clamped to NCH/2-1, which is 31 by default. When that bit is 1 the programmed high bound is used.
- R4: Control bits 1:0 at offset 4 select the trigger: 0 software, 1 external falling edge, 2 external rising edge, 3 pacer tick. In software mode a write to offset 0 starts one conversion. In any other mode that write starts nothing.
- R5: The external trigger passes through a two-stage synchronizer. Each edge of the selected polarity starts exactly one conversion, with the strobe appearing within four cycles. Edges of the other polarity start nothing.
- R6: In pacer mode each one-cycle tick starts exactly one conversion.
- R7: The start strobe lasts one cycle. A trigger that arrives between a strobe and the matching converter done pulse is dropped.
- R8: Each sample word is 16 bits, with the 12-bit result in bits 15:4 and zeros below. Offset 0 reads the low byte of the oldest word. Offset 1 reads its high byte and removes the word. Words come out in conversion order.
- R9: The status byte at offset 6 has bit 0 set when the FIFO is not empty, bit 1 set at half-full or more, bit 2 set when full, and bit 3 set for the end-of-scan flag. A sample that arrives while the FIFO is full is dropped.
- R10: The interrupt request is control bit 7 ANDed with a cause chosen by mode bits 3:2: 0 gives none, 1 FIFO not empty, 2 FIFO at least half full, 3 end-of-scan flag. The flag is set by a conversion that wraps the channel and cleared by any write to offset 6.
- R11: Mode bit 5 drives `singleEnded`, mode bit 6 drives `unipolar`, and control bits 6:4 drive `irqLine`. Mode is at offset 5. All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, asynchronous assert |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (pops on offset 1) |
| busAddr | input | 4 | Register byte offset |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr |
| extTrig | input | 1 | Asynchronous external trigger |
| pacerTick | input | 1 | One-cycle pacer pulse |
| convDone | input | 1 | Converter completion pulse |
| convData | input | ADC_BITS | Converter result, valid with convDone |
| muxSel | output | CHW | Current multiplexer channel |
| socPulse | output | 1 | Start-of-conversion strobe |
| singleEnded | output | 1 | Input configuration to front end |
| unipolar | output | 1 | Coding selection to front end |
| irqReq | output | 1 | Interrupt request |
| irqLine | output | 3 | Interrupt line selection code |

## Verification
A wrong channel counter shows up as a wrong sample word on the very next read. Each stored word carries the channel it was converted on, so a stepping, wrap or clamp error is visible at the data port one conversion after it happens. A stuck busy flag appears as a missing or extra start strobe within a few cycles of a trigger. A wrong FIFO pointer or count appears at once in the status byte, in the interrupt request, or in the order of the words read back.

// File: rtl/acq_scan_pkg.sv
package acq_scan_pkg;

  localparam logic [3:0] OFS_DATA_LO = 4'h0;
  localparam logic [3:0] OFS_DATA_HI = 4'h1;
  localparam logic [3:0] OFS_MUX_LO  = 4'h2;
  localparam logic [3:0] OFS_MUX_HI  = 4'h3;
  localparam logic [3:0] OFS_CTRL    = 4'h4;
  localparam logic [3:0] OFS_MODE    = 4'h5;
  localparam logic [3:0] OFS_STATUS  = 4'h6;

  typedef enum logic [1:0] {
    TRG_SOFT = 2'd0,
    TRG_FALL = 2'd1,
    TRG_RISE = 2'd2,
    TRG_PACE = 2'd3
  } trigSrc_t;

  typedef enum logic [1:0] {
    IRQ_NONE  = 2'd0,
    IRQ_NEMPTY = 2'd1,
    IRQ_HALF  = 2'd2,
    IRQ_BURST = 2'd3
  } irqSrc_t;

  // strobes from control to datapath
  typedef struct packed {
    logic sampleDone;
    logic reloadChan;
    logic popFifo;
    logic clrBurst;
  } seqStrobe_t;

endpackage

// File: rtl/acq_scan_datapath.sv
module acq_scan_datapath
  import acq_scan_pkg::*;
#(
  parameter int NCH      = 64,
  parameter int ADC_BITS = 12,
  parameter int WORD     = 16,
  parameter int DEPTH    = 16,
  localparam int CHW     = $clog2(NCH),
  localparam int PTRW    = $clog2(DEPTH),
  localparam int CNTW    = $clog2(DEPTH + 1),
  localparam int HALF    = NCH / 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic [CHW-1:0]      lowBound,
  input  logic [CHW-1:0]      highBound,
  input  logic                seMode,
  input  logic [ADC_BITS-1:0] convData,
  output logic [CHW-1:0]      muxSel,
  output logic [WORD-1:0]     headWord,
  output logic                notEmpty,
  output logic                halfFull,
  output logic                full,
  output logic                burstFlag
);

  logic [CHW-1:0]  curChan;
  logic [CHW-1:0]  effHigh;
  logic            atTop;
  logic [WORD-1:0] sampleWord;
  logic [WORD-1:0] mem [DEPTH];
  logic [PTRW-1:0] wrPtr, rdPtr;
  logic [CNTW-1:0] fillCount;
  logic            doPush, doPop;

  always_comb begin
    if (!seMode && highBound > CHW'(HALF - 1)) effHigh = CHW'(HALF - 1);
    else                                       effHigh = highBound;
  end

  assign atTop = (curChan >= effHigh);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curChan <= '0;
    end else if (strobe.reloadChan) begin
      curChan <= lowBound;
    end else if (strobe.sampleDone) begin
      curChan <= atTop ? lowBound : curChan + CHW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          burstFlag <= 1'b0;
    else if (strobe.sampleDone && atTop) burstFlag <= 1'b1;
    else if (strobe.clrBurst)           burstFlag <= 1'b0;
  end

  assign muxSel = curChan;

  generate
    if (WORD == ADC_BITS) begin : g_full
      assign sampleWord = convData;
    end else begin : g_left
      assign sampleWord = {convData, {(WORD - ADC_BITS){1'b0}}};
    end
  endgenerate

  assign full     = (fillCount == CNTW'(DEPTH));
  assign notEmpty = (fillCount != '0);
  assign halfFull = (fillCount >= CNTW'(DEPTH / 2));
  assign doPush   = strobe.sampleDone && !full;
  assign doPop    = strobe.popFifo && notEmpty;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= sampleWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + PTRW'(1);
      if (doPop)  rdPtr <= rdPtr + PTRW'(1);
      case ({doPush, doPop})
        2'b10:   fillCount <= fillCount + CNTW'(1);
        2'b01:   fillCount <= fillCount - CNTW'(1);
        default: fillCount <= fillCount;
      endcase
    end
  end

  assign headWord = notEmpty ? mem[rdPtr] : '0;

  // R1
  chan_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reloadChan |=> (curChan == $past(lowBound)));

  // R2
  chan_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sampleDone && !strobe.reloadChan && lowBound <= effHigh)
      |=> (curChan >= $past(lowBound) && curChan <= $past(effHigh)));

  // R3
  diff_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!seMode && strobe.sampleDone && !strobe.reloadChan && lowBound < CHW'(HALF))
      |=> (curChan < CHW'(HALF)));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (full && strobe.sampleDone && !strobe.popFifo) |=> (fillCount == CNTW'(DEPTH)));

endmodule

// File: rtl/acq_scan_control.sv
module acq_scan_control
  import acq_scan_pkg::*;
#(
  parameter int NCH  = 64,
  parameter int WORD = 16,
  localparam int CHW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            busWr,
  input  logic            busRd,
  input  logic [3:0]      busAddr,
  input  logic [7:0]      busWrData,
  output logic [7:0]      busRdData,
  input  logic            extTrig,
  input  logic            pacerTick,
  input  logic            convDone,
  input  logic [WORD-1:0] headWord,
  input  logic            notEmpty,
  input  logic            halfFull,
  input  logic            full,
  input  logic            burstFlag,
  output seqStrobe_t      strobe,
  output logic [CHW-1:0]  lowBound,
  output logic [CHW-1:0]  highBound,
  output logic            seMode,
  output logic            socPulse,
  output logic            unipolar,
  output logic            irqReq,
  output logic [2:0]      irqLine
);

  logic [7:0] ctrlReg, modeReg;
  logic       extS1, extS2, extS3;
  logic       busy, trigHit, startConv, reloadPend, irqCause;
  trigSrc_t   trigSel;
  irqSrc_t    irqSel;

  assign trigSel = trigSrc_t'(ctrlReg[1:0]);
  assign irqSel  = irqSrc_t'(modeReg[3:2]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowBound  <= '0;
      highBound <= '0;
      ctrlReg   <= '0;
      modeReg   <= '0;
    end else if (busWr) begin
      case (busAddr)
        OFS_MUX_LO: lowBound  <= busWrData[CHW-1:0];
        OFS_MUX_HI: highBound <= busWrData[CHW-1:0];
        OFS_CTRL:   ctrlReg   <= busWrData;
        OFS_MODE:   modeReg   <= busWrData;
        default: ;
      endcase
    end
  end

  // reload one cycle after the bound write so the new bound is in place
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reloadPend <= 1'b0;
    else       reloadPend <= busWr && (busAddr == OFS_MUX_LO || busAddr == OFS_MUX_HI);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) {extS1, extS2, extS3} <= 3'b000;
    else       {extS1, extS2, extS3} <= {extTrig, extS1, extS2};
  end

  always_comb begin
    case (trigSel)
      TRG_SOFT: trigHit = busWr && (busAddr == OFS_DATA_LO);
      TRG_FALL: trigHit = !extS2 && extS3;
      TRG_RISE: trigHit = extS2 && !extS3;
      default:  trigHit = pacerTick;
    endcase
  end

  assign startConv = trigHit && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      socPulse <= 1'b0;
    end else begin
      socPulse <= startConv;
      if (startConv)     busy <= 1'b1;
      else if (convDone) busy <= 1'b0;
    end
  end

  always_comb begin
    strobe.sampleDone = convDone && busy;
    strobe.reloadChan = reloadPend;
    strobe.popFifo    = busRd && (busAddr == OFS_DATA_HI);
    strobe.clrBurst   = busWr && (busAddr == OFS_STATUS);
  end

  always_comb begin
    case (irqSel)
      IRQ_NEMPTY: irqCause = notEmpty;
      IRQ_HALF:   irqCause = halfFull;
      IRQ_BURST:  irqCause = burstFlag;
      default:    irqCause = 1'b0;
    endcase
  end

  assign irqReq   = ctrlReg[7] && irqCause;
  assign irqLine  = ctrlReg[6:4];
  assign seMode   = modeReg[5];
  assign unipolar = modeReg[6];

  always_comb begin
    case (busAddr)
      OFS_DATA_LO: busRdData = headWord[7:0];
      OFS_DATA_HI: busRdData = headWord[15:8];
      OFS_MUX_LO:  busRdData = 8'(lowBound);
      OFS_MUX_HI:  busRdData = 8'(highBound);
      OFS_CTRL:    busRdData = ctrlReg;
      OFS_MODE:    busRdData = modeReg;
      OFS_STATUS:  busRdData = {4'b0000, burstFlag, full, halfFull, notEmpty};
      default:     busRdData = 8'h00;
    endcase
  end

  // R7
  soc_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    socPulse |=> !socPulse);

  // R7
  busy_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !convDone) |=> (!socPulse && busy));

endmodule

// File: rtl/acq_scan_ctrl.sv
module acq_scan_ctrl
  import acq_scan_pkg::*;
#(
  parameter int NCH      = 64,
  parameter int ADC_BITS = 12,
  parameter int DEPTH    = 16,
  localparam int CHW     = $clog2(NCH),
  localparam int WORD    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWr,
  input  logic                busRd,
  input  logic [3:0]          busAddr,
  input  logic [7:0]          busWrData,
  output logic [7:0]          busRdData,
  input  logic                extTrig,
  input  logic                pacerTick,
  input  logic                convDone,
  input  logic [ADC_BITS-1:0] convData,
  output logic [CHW-1:0]      muxSel,
  output logic                socPulse,
  output logic                singleEnded,
  output logic                unipolar,
  output logic                irqReq,
  output logic [2:0]          irqLine
);

  seqStrobe_t      strobe;
  logic [CHW-1:0]  lowBound, highBound;
  logic            seMode;
  logic [WORD-1:0] headWord;
  logic            notEmpty, halfFull, full, burstFlag;

  acq_scan_control #(.NCH(NCH), .WORD(WORD)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .extTrig(extTrig), .pacerTick(pacerTick), .convDone(convDone),
    .headWord(headWord), .notEmpty(notEmpty), .halfFull(halfFull),
    .full(full), .burstFlag(burstFlag),
    .strobe(strobe), .lowBound(lowBound), .highBound(highBound),
    .seMode(seMode), .socPulse(socPulse), .unipolar(unipolar),
    .irqReq(irqReq), .irqLine(irqLine)
  );

  acq_scan_datapath #(.NCH(NCH), .ADC_BITS(ADC_BITS), .WORD(WORD), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lowBound(lowBound), .highBound(highBound), .seMode(seMode),
    .convData(convData), .muxSel(muxSel), .headWord(headWord),
    .notEmpty(notEmpty), .halfFull(halfFull), .full(full),
    .burstFlag(burstFlag)
  );

  assign singleEnded = seMode;

endmodule

// File: tb/sim_acq_scan_ctrl.sv
module sim_acq_scan_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic        extTrig = 1'b0, pacerTick = 1'b0;
  logic        convDone = 1'b0;
  logic [11:0] convData = '0;
  logic [5:0]  muxSel;
  logic        socPulse, singleEnded, unipolar, irqReq;
  logic [2:0]  irqLine;

  int nChecks = 0, nFails = 0, socCnt = 0, pendCnt = 0;
  logic [5:0] capChan = '0;
  bit done = 0;

  always #2 clk = ~clk;

  acq_scan_ctrl u0 (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .extTrig(extTrig),
    .pacerTick(pacerTick), .convDone(convDone), .convData(convData),
    .muxSel(muxSel), .socPulse(socPulse), .singleEnded(singleEnded),
    .unipolar(unipolar), .irqReq(irqReq), .irqLine(irqLine)
  );

  // converter model: done pulse three cycles after the strobe, data tagged with channel
  always @(negedge clk) begin
    convDone = 1'b0;
    if (pendCnt > 0) begin
      pendCnt = pendCnt - 1;
      if (pendCnt == 0) begin
        convDone = 1'b1;
        convData = 12'hA00 | {6'd0, capChan};
      end
    end
    if (socPulse) begin
      socCnt  = socCnt + 1;
      capChan = muxSel;
      pendCnt = 3;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic rdReg(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); busAddr = a; #1 v = busRdData;
  endtask

  task automatic readWord(output int w);
    logic [7:0] lo, hi;
    @(negedge clk); busAddr = 4'h0; #1 lo = busRdData;
    @(negedge clk); busAddr = 4'h1; busRd = 1'b1; #1 hi = busRdData;
    @(negedge clk); busRd = 1'b0;
    w = {16'd0, hi, lo};
  endtask

  task automatic softConv();
    wr(4'h0, 8'h00);
    repeat (6) @(negedge clk);
  endtask

  function automatic int expWord(input int ch);
    return 32'hA000 | (ch << 4);
  endfunction

  function automatic int nextChan(input int c, input int lo, input int hi, input int se);
    int eh;
    eh = (!se && hi > 31) ? 31 : hi;
    return (c >= eh) ? lo : c + 1;
  endfunction

  // vector: {lo, hi, singleEnded, conversions}
  localparam logic [31:0] VEC [5] = '{
    {8'd2,  8'd5,  8'd1, 8'd6},
    {8'd7,  8'd7,  8'd1, 8'd3},
    {8'd30, 8'd40, 8'd0, 8'd5},
    {8'd60, 8'd63, 8'd1, 8'd6},
    {8'd20, 8'd40, 8'd1, 8'd4}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int w, c, s0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state (R1, R11)
    chk("R1 reset muxSel", muxSel, 0);
    chk("R7 reset soc", socPulse, 0);
    chk("R10 reset irq", irqReq, 0);
    chk("R11 reset se/uni/line", {singleEnded, unipolar, irqLine}, 0);
    rdReg(4'h6, v); chk("R9 reset status", v, 0);

    // table walk: stepping, wrap, clamp (R2, R3, R8)
    for (int i = 0; i < 5; i++) begin
      int lo, hi, se, n;
      lo = VEC[i][31:24]; hi = VEC[i][23:16]; se = VEC[i][15:8]; n = VEC[i][7:0];
      wr(4'h5, se ? 8'h20 : 8'h00);
      wr(4'h2, 8'(lo));
      wr(4'h3, 8'(hi));
      repeat (2) @(negedge clk);
      chk("R1 reload to low", muxSel, lo);
      for (int k = 0; k < n; k++) softConv();
      c = lo;
      for (int k = 0; k < n; k++) begin
        readWord(w);
        chk(se ? "R2 scan word" : "R3 clamped scan word", w, expWord(c));
        c = nextChan(c, lo, hi, se);
      end
    end
    rdReg(4'h2, v); chk("R1 low readback", v, 20);

    // rewrite mid-scan resets channel (R1)
    wr(4'h2, 8'd10); wr(4'h3, 8'd20);
    softConv(); softConv();
    repeat (2) @(negedge clk);
    chk("R1 advanced before rewrite", muxSel, 12);
    wr(4'h3, 8'd20);
    repeat (2) @(negedge clk);
    chk("R1 rewrite high resets", muxSel, 10);
    readWord(w); readWord(w);
    chk("R8 fifo order second word", w, expWord(11));

    // pass-through (R11)
    wr(4'h5, 8'h60);
    @(negedge clk);
    chk("R11 se/uni set", {singleEnded, unipolar}, 2'b11);
    wr(4'h5, 8'h20);

    // software write ignored in pacer mode, pacer tick counts (R4, R6)
    wr(4'h4, 8'h03);
    s0 = socCnt;
    wr(4'h0, 8'h00);
    repeat (6) @(negedge clk);
    chk("R4 soft write ignored in pacer mode", socCnt, s0);
    @(negedge clk); pacerTick = 1'b1; @(negedge clk); pacerTick = 1'b0;
    repeat (6) @(negedge clk);
    chk("R6 one conversion per tick", socCnt, s0 + 1);
    readWord(w);

    // external edges (R5)
    wr(4'h4, 8'h02);
    s0 = socCnt;
    @(negedge clk); extTrig = 1'b1;
    repeat (5) @(negedge clk);
    chk("R5 rising edge starts", socCnt, s0 + 1);
    extTrig = 1'b0;
    repeat (8) @(negedge clk);
    chk("R5 falling ignored in rise mode", socCnt, s0 + 1);
    wr(4'h4, 8'h01);
    @(negedge clk); extTrig = 1'b1;
    repeat (8) @(negedge clk);
    chk("R5 rising ignored in fall mode", socCnt, s0 + 1);
    extTrig = 1'b0;
    repeat (5) @(negedge clk);
    chk("R5 falling edge starts", socCnt, s0 + 2);
    repeat (4) @(negedge clk);
    readWord(w); readWord(w);

    // trigger while busy dropped (R7)
    wr(4'h4, 8'h00);
    s0 = socCnt;
    wr(4'h0, 8'h00); wr(4'h0, 8'h00);
    repeat (8) @(negedge clk);
    chk("R7 trigger during busy dropped", socCnt, s0 + 1);
    readWord(w);
    rdReg(4'h6, v); chk("R8 fifo drained", v & 8'h07, 0);

    // full and drop (R9)
    wr(4'h2, 8'd0); wr(4'h3, 8'd63);
    for (int k = 0; k < 18; k++) softConv();
    rdReg(4'h6, v); chk("R9 status full", v & 8'h07, 8'h07);
    for (int k = 0; k < 16; k++) begin
      readWord(w); chk("R9 stored words before drop", w, expWord(k));
    end
    rdReg(4'h6, v); chk("R9 empty after drain", v & 8'h07, 0);

    // interrupt causes (R10, R11)
    wr(4'h6, 8'h00);
    wr(4'h4, 8'hD0);
    chk("R11 irq line", irqLine, 5);
    wr(4'h5, 8'h24);
    chk("R10 not-empty idle", irqReq, 0);
    softConv();
    chk("R10 not-empty raised", irqReq, 1);
    readWord(w);
    @(negedge clk);
    chk("R10 not-empty cleared", irqReq, 0);
    wr(4'h5, 8'h28);
    for (int k = 0; k < 7; k++) softConv();
    chk("R10 below half", irqReq, 0);
    softConv();
    chk("R10 half raised", irqReq, 1);
    for (int k = 0; k < 8; k++) readWord(w);
    wr(4'h5, 8'h2C);
    wr(4'h2, 8'd3); wr(4'h3, 8'd4);
    repeat (2) @(negedge clk);
    softConv();
    chk("R10 no burst mid-window", irqReq, 0);
    softConv();
    chk("R10 burst raised on wrap", irqReq, 1);
    rdReg(4'h6, v); chk("R9 burst status bit", v & 8'h08, 8'h08);
    wr(4'h6, 8'h00);
    @(negedge clk);
    chk("R10 burst cleared by status write", irqReq, 0);
    readWord(w); readWord(w);
    wr(4'h4, 8'h50);
    wr(4'h5, 8'h24);
    softConv();
    chk("R10 enable off blocks", irqReq, 0);
    readWord(w);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule